// File: doc/BRIEF.md
# Ring Descriptor DMA Reader

This block is a fetch engine that walks a linked chain of descriptors held in word-addressed memory and streams the bytes of each described buffer, in order, into a small output FIFO that feeds a peripheral. Each descriptor spans three consecutive words: the first holds a buffer address, the second holds the control word, and the third holds the address of the next descriptor. The control word carries a byte count and a completion-flag bit. When the last descriptor points back at the first, the engine circles the ring with no further help from software. A flagged descriptor raises an interrupt once its final byte has been fetched, so a block that spans several buffers produces one interrupt.

Software loads the descriptor pointer while the engine is idle. It starts the engine with a control write that sets both the active bit and the active-load bit, and stops it with a control write that sets active-load and clears active. The same register holds a high-water mark that limits how full the FIFO may get before fetching pauses. It also holds a realtime bit and two FIFO window fields. These three are kept and read back for the peripheral side. Reading the control register returns the interrupt-pending bit and clears it.

The memory port is a plain read port. The engine drives `mem_rd` and `mem_addr`, and the memory answers on `mem_rdata` within the same cycle. The output is a valid/ready byte stream. The engine holds `out_valid` and `out_data` steady until the sink takes the byte with `out_ready`. A stalled sink only fills the FIFO up to the high-water mark, after which the engine stops issuing reads. Nothing is ever dropped.

Top module: `dma_ring_reader`

## Requirements
- R1: A descriptor at word address D is read from D (buffer word address), D+1 (bits 15:0 byte length, bit 31 completion flag) and D+2 (next descriptor address). Byte i of its buffer is lane i mod 4 of word (buffer + i/4), with lane 0 in bits 7:0. The bytes leave on the stream in increasing i.
- R2: After a descriptor's last byte, the engine continues at its next pointer. A ring therefore repeats its byte sequence indefinitely.
- R3: A descriptor of length 0 emits no byte and never raises the interrupt, even when it is flagged. The engine moves on to its next pointer.
- R4: The interrupt-pending state is set when the final byte of a flagged descriptor enters the FIFO. Unflagged descriptors never set it. The `irq` output follows the pending state.
- R5: A read of the control register (`csr_addr`=0) returns the pending state in bit 3 and clears it. The clear does not happen if a new completion arrives in the same cycle.
- R6: A control write with bit 1 (active-load) set copies bit 0 into the active state. Fetching then begins at the descriptor pointer. A control write with bit 1 clear leaves the active state unchanged. Bit 0 reads back as the active state and bit 1 always reads back as 0.
- R7: A control write with bit 1 set and bit 0 clear stops all memory reads and FIFO pushes. Bytes already in the FIFO still drain to the stream.
- R8: The high-water field is control bits 11:8. The engine pushes a byte only while the FIFO level is below the effective mark. The effective mark is the field value, or the FIFO depth when the field is 0 or exceeds the depth.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged in the next cycle.
- R10: After reset the control register reads 0, the descriptor pointer reads 0, and `irq` and `out_valid` are low.
- R11: A write to `csr_addr`=1 loads the descriptor pointer only while the engine is inactive and is ignored while it is active. Reading `csr_addr`=1 returns the address of the descriptor in use.
- R12: The realtime bit (bit 2), FIFO-begin field (bits 19:16) and FIFO-end field (bits 27:24) are written by any control write and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe (clears interrupt-pending on control reads) |
| csr_addr | input | 1 | 0 selects the control register, 1 selects the descriptor pointer |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, valid in the same cycle |
| irq | output | 1 | Interrupt-pending state |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | 32 | Memory read data, returned in the request cycle |
| out_valid | output | 1 | Stream byte available |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Stream byte |

## Verification
The hardest condition to reach is the high-water limit. The sink must be held off long enough that the FIFO level sits exactly at the mark, which the ports never show directly. The stimulus uses a ring with one flagged three-byte descriptor and stalls the sink with a mark of two. A missing interrupt then shows that the third byte was never fetched. Raising the mark to four while the sink is still stalled must then produce the interrupt. Randomized rings with zero-length entries and random sink stalls then compare the whole byte stream against a model that walks the bench's own memory.

// File: rtl/dma_ring_pkg.sv
`timescale 1ns/1ps
package dma_ring_pkg;
  typedef enum logic [2:0] {
    WS_IDLE,
    WS_BUF,
    WS_CTL,
    WS_NXT,
    WS_XFER
  } walk_st_t;

  localparam int CTL_ACT     = 0;
  localparam int CTL_LOAD    = 1;
  localparam int CTL_RT      = 2;
  localparam int CTL_PEND    = 3;
  localparam int FLD_W       = 4;
  localparam int HW_LSB      = 8;
  localparam int BEG_LSB     = 16;
  localparam int END_LSB     = 24;
  localparam int LEN_W       = 16;
  localparam int DESC_FLAG   = 31;
  localparam int WORD_W      = 32;

  typedef struct packed {
    logic             rt;
    logic [FLD_W-1:0] hw;
    logic [FLD_W-1:0] fbeg;
    logic [FLD_W-1:0] fend;
  } ctl_fields_t;
endpackage

// File: rtl/dma_byte_fifo.sv
`timescale 1ns/1ps
module dma_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wp] <= push_data;
  end
endmodule

// File: rtl/dma_csr.sv
`timescale 1ns/1ps
module dma_csr
  import dma_ring_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic              csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  input  logic              irq_set,
  input  logic [AW-1:0]     cur_ptr,
  output logic              active,
  output logic              irq,
  output ctl_fields_t       fields,
  output logic              ptr_load,
  output logic [AW-1:0]     ptr_val
);
  logic ctl_wr, ctl_rd;

  assign ctl_wr   = csr_wr && !csr_addr;
  assign ctl_rd   = csr_rd && !csr_addr;
  assign ptr_load = csr_wr && csr_addr && !active;
  assign ptr_val  = csr_wdata[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      irq    <= 1'b0;
      fields <= '0;
    end else begin
      if (ctl_wr) begin
        if (csr_wdata[CTL_LOAD]) active <= csr_wdata[CTL_ACT];
        fields.rt   <= csr_wdata[CTL_RT];
        fields.hw   <= csr_wdata[HW_LSB +: FLD_W];
        fields.fbeg <= csr_wdata[BEG_LSB +: FLD_W];
        fields.fend <= csr_wdata[END_LSB +: FLD_W];
      end
      if (irq_set)     irq <= 1'b1;
      else if (ctl_rd) irq <= 1'b0;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_addr) begin
      csr_rdata = WORD_W'(cur_ptr);
    end else begin
      csr_rdata[CTL_ACT]               = active;
      csr_rdata[CTL_RT]                = fields.rt;
      csr_rdata[CTL_PEND]              = irq;
      csr_rdata[HW_LSB +: FLD_W]       = fields.hw;
      csr_rdata[BEG_LSB +: FLD_W]      = fields.fbeg;
      csr_rdata[END_LSB +: FLD_W]      = fields.fend;
    end
  end
endmodule

// File: rtl/dma_walker.sv
`timescale 1ns/1ps
module dma_walker
  import dma_ring_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [LW-1:0]     hw_eff,
  input  logic [LW-1:0]     fifo_level,
  input  logic              ptr_load,
  input  logic [AW-1:0]     ptr_val,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              push,
  output logic [7:0]        push_data,
  output logic              done_irq,
  output logic [AW-1:0]     cur_ptr
);
  walk_st_t         st;
  logic [AW-1:0]    buf_q, nxt_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             flag_q;
  logic             room, last_byte;
  logic [WORD_W-1:0] lane_shift;

  assign room       = fifo_level < hw_eff;
  assign push       = active && (st == WS_XFER) && room;
  assign last_byte  = (cnt_q == len_q - 1'b1);
  assign done_irq   = push && last_byte && flag_q;
  assign lane_shift = mem_rdata >> {cnt_q[1:0], 3'b000};
  assign push_data  = lane_shift[7:0];

  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = cur_ptr;
    if (active) begin
      case (st)
        WS_BUF: begin mem_rd = 1'b1; mem_addr = cur_ptr; end
        WS_CTL: begin mem_rd = 1'b1; mem_addr = cur_ptr + AW'(1); end
        WS_NXT: begin mem_rd = 1'b1; mem_addr = cur_ptr + AW'(2); end
        WS_XFER: begin
          mem_rd   = room;
          mem_addr = buf_q + AW'(cnt_q >> 2);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= WS_IDLE;
      cur_ptr <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
    end else if (!active) begin
      st <= WS_IDLE;
      if (ptr_load) cur_ptr <= ptr_val;
    end else begin
      case (st)
        WS_IDLE: st <= WS_BUF;
        WS_BUF: begin
          buf_q <= mem_rdata[AW-1:0];
          st    <= WS_CTL;
        end
        WS_CTL: begin
          len_q  <= mem_rdata[LEN_W-1:0];
          flag_q <= mem_rdata[DESC_FLAG];
          st     <= WS_NXT;
        end
        WS_NXT: begin
          nxt_q <= mem_rdata[AW-1:0];
          cnt_q <= '0;
          if (len_q == '0) begin
            cur_ptr <= mem_rdata[AW-1:0];
            st      <= WS_BUF;
          end else begin
            st <= WS_XFER;
          end
        end
        WS_XFER: begin
          if (room) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_byte) begin
              cur_ptr <= nxt_q;
              st      <= WS_BUF;
            end
          end
        end
        default: st <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_ring_reader.sv
`timescale 1ns/1ps
module dma_ring_reader
  import dma_ring_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic              csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  output logic              irq,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data
);
  logic          active, ptr_load, fifo_push, done_irq, fifo_empty, fifo_full;
  logic [AW-1:0] ptr_val, cur_ptr;
  logic [7:0]    push_data;
  logic [LW-1:0] fifo_level, hw_eff;
  ctl_fields_t   fields;

  always_comb begin
    if (fields.hw == '0 || int'(fields.hw) > DEPTH) hw_eff = LW'(DEPTH);
    else                                             hw_eff = LW'(fields.hw);
  end

  dma_csr #(.AW(AW)) u_csr (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_set(done_irq), .cur_ptr(cur_ptr), .active(active), .irq(irq),
    .fields(fields), .ptr_load(ptr_load), .ptr_val(ptr_val)
  );

  dma_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst_n(rst_n), .active(active), .hw_eff(hw_eff),
    .fifo_level(fifo_level), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .push(fifo_push), .push_data(push_data), .done_irq(done_irq),
    .cur_ptr(cur_ptr)
  );

  dma_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_data(push_data),
    .pop(out_valid && out_ready), .head(out_data), .empty(fifo_empty),
    .full(fifo_full), .level(fifo_level)
  );

  assign out_valid = !fifo_empty;
endmodule

// File: rtl/dma_ring_reader_chk.sv
`timescale 1ns/1ps
module dma_ring_reader_chk #(
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          irq,
  input logic          fifo_push,
  input logic          fifo_full,
  input logic [LW-1:0] fifo_level,
  input logic [LW-1:0] hw_eff,
  input logic          active,
  input logic          done_irq,
  input logic          csr_rd,
  input logic          csr_addr
);
  a_r9_hold_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r8_below_mark: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (fifo_level < hw_eff));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);

  a_r7_idle_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !fifo_push);

  a_r4_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_irq));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && !csr_addr && !done_irq) |=> !irq);
endmodule

bind dma_ring_reader dma_ring_reader_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .irq(irq), .fifo_push(fifo_push), .fifo_full(fifo_full),
  .fifo_level(fifo_level), .hw_eff(hw_eff), .active(active),
  .done_irq(done_irq), .csr_rd(csr_rd), .csr_addr(csr_addr)
);

// File: tb/dma_ring_reader_bench.sv
`timescale 1ns/1ps
module dma_ring_reader_bench;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0, csr_rd = 1'b0, csr_addr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq, mem_rd, out_valid, out_data_unused;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic [31:0] mem [256];

  int checks = 0;
  int fails  = 0;
  int r_desc [3];
  int r_buf  [3];
  int r_len  [3];
  int sidx   = 0;

  always #2.5 clk = ~clk;
  assign mem_rdata = mem[mem_addr[7:0]];
  assign out_data_unused = 1'b0;

  dma_ring_reader #(.AW(AW), .DEPTH(8)) u_dma_ring_reader (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq(irq), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input bit act, input bit ld, input bit rt,
                                      input int hw, input int fb, input int fe);
    logic [31:0] w = '0;
    w[0] = act; w[1] = ld; w[2] = rt;
    w[11:8] = hw[3:0]; w[19:16] = fb[3:0]; w[27:24] = fe[3:0];
    return w;
  endfunction

  function automatic logic [7:0] exp_byte(input int k);
    int tot = r_len[0] + r_len[1] + r_len[2];
    int m = k % tot;
    for (int d = 0; d < 3; d++) begin
      if (m < r_len[d]) return 8'(mem[8'(r_buf[d] + m / 4)] >> (8 * (m % 4)));
      m -= r_len[d];
    end
    return 8'h00;
  endfunction

  task automatic build_ring(input int base, input int bbase, input bit [2:0] flg);
    for (int d = 0; d < 3; d++) begin
      r_desc[d] = base + 3 * d;
      r_buf[d]  = bbase + 4 * d;
      mem[8'(r_desc[d])]     = 32'(r_buf[d]);
      mem[8'(r_desc[d] + 1)] = {flg[d], 15'd0, 16'(r_len[d])};
      mem[8'(r_desc[d] + 2)] = 32'((d == 2) ? base : base + 3 * (d + 1));
      for (int w = 0; w < 4; w++) mem[8'(r_buf[d] + w)] = $urandom;
    end
    sidx = 0;
  endtask

  task automatic csr_write(input bit a, input logic [31:0] v);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = v;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(input bit a, output logic [31:0] v);
    csr_rd = 1'b1; csr_addr = a;
    #1 v = csr_rdata;
    @(negedge clk);
    csr_rd = 1'b0;
  endtask

  task automatic collect(input int n, input bit rnd, input string req);
    int got = 0;
    int cyc = 0;
    while (got < n && cyc < 3000) begin
      out_ready = rnd ? 1'($urandom % 2) : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        check(out_data == exp_byte(sidx), req, 32'(out_data), 32'(exp_byte(sidx)));
        sidx++; got++;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    check(got == n, {req, " count"}, 32'(got), 32'(n));
  endtask

  task automatic stop_and_drain(input string req);
    csr_write(1'b0, ctl(1'b0, 1'b1, 1'b0, 8, 0, 0));
    for (int i = 0; i < 20; i++) begin
      out_ready = 1'b1;
      #1;
      if (out_valid) begin
        check(out_data == exp_byte(sidx), req, 32'(out_data), 32'(exp_byte(sidx)));
        sidx++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    repeat (10) @(negedge clk);
    check(!out_valid, {req, " no new bytes after stop"}, 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit seen;
    void'($urandom(32'd7321));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    csr_read(1'b0, v); check(v == 0, "R10 ctrl after reset", v, 0);
    csr_read(1'b1, v); check(v == 0, "R10 pointer after reset", v, 0);
    check(!irq && !out_valid, "R10 irq/out_valid low", {30'd0, irq, out_valid}, 0);

    // R6 load bit clear leaves engine inactive; R12 field readback
    r_len[0] = 5; r_len[1] = 0; r_len[2] = 7;
    build_ring(8'h10, 8'h40, 3'b110);
    csr_write(1'b1, 32'h10);
    csr_write(1'b0, ctl(1'b1, 1'b0, 1'b1, 5, 3, 9));
    repeat (20) @(negedge clk);
    check(!out_valid, "R6 no fetch without load bit", 32'(out_valid), 0);
    csr_read(1'b0, v);
    check(v[0] == 1'b0 && v[1] == 1'b0, "R6 active unchanged", v, 0);
    check(v[2] == 1'b1 && v[11:8] == 4'd5, "R12 realtime/high-water", v, 32'h504);
    check(v[19:16] == 4'd3 && v[27:24] == 4'd9, "R12 fifo window fields", v, 32'h0903_0000);
    csr_read(1'b1, v); check(v == 32'h10, "R11 pointer loaded while idle", v, 32'h10);

    // R1 R3 R4 R5 R2: ring 5,0(flagged),7(flagged), high-water 2
    csr_write(1'b0, ctl(1'b1, 1'b1, 1'b0, 2, 0, 0));
    collect(5, 1'b1, "R1 first descriptor bytes");
    check(!irq, "R3 flagged zero-length raises no irq", 32'(irq), 0);
    collect(7, 1'b1, "R3 zero-length contributes no bytes");
    check(irq, "R4 irq after flagged descriptor", 32'(irq), 1);
    csr_read(1'b0, v); check(v[3] == 1'b1, "R5 pending bit reads set", v[3], 1);
    csr_read(1'b0, v); check(v[3] == 1'b0 && !irq, "R5 pending cleared by read", v[3], 0);
    collect(12, 1'b1, "R2 ring repeats sequence");
    csr_write(1'b1, 32'h33);
    stop_and_drain("R7 drain after stop");
    csr_read(1'b1, v);
    seen = (v == 32'h10) || (v == 32'h13) || (v == 32'h16);
    check(seen, "R11 pointer write ignored while active", v, 32'h10);
    csr_read(1'b0, v); check(v[0] == 1'b0, "R7 active reads 0", v, 0);

    // R8 high-water: single 3-byte flagged descriptor looping on itself
    mem[8'h20] = 32'h70; mem[8'h21] = {1'b1, 15'd0, 16'd3}; mem[8'h22] = 32'h20;
    mem[8'h70] = $urandom;
    r_desc[0] = 8'h20; r_buf[0] = 8'h70; r_len[0] = 3; r_len[1] = 0; r_len[2] = 0;
    r_buf[1] = 8'h70; r_buf[2] = 8'h70; sidx = 0;
    csr_read(1'b0, v);
    csr_write(1'b1, 32'h20);
    csr_write(1'b0, ctl(1'b1, 1'b1, 1'b0, 2, 0, 0));
    repeat (40) @(negedge clk);
    check(!irq, "R8 fetch halts at mark 2", 32'(irq), 0);
    v = 32'(out_data);
    @(negedge clk);
    check(out_valid && out_data == v[7:0], "R9 data held under stall", 32'(out_data), v);
    csr_write(1'b0, ctl(1'b1, 1'b0, 1'b0, 4, 0, 0));
    repeat (20) @(negedge clk);
    check(irq, "R8 fetch resumes below raised mark", 32'(irq), 1);
    collect(9, 1'b1, "R2 self-looping descriptor");
    stop_and_drain("R7 drain after stop");

    // Random rings
    for (int rnd = 0; rnd < 5; rnd++) begin
      r_len[0] = 1 + int'($urandom % 9);
      r_len[1] = int'($urandom % 10);
      r_len[2] = int'($urandom % 10);
      build_ring(8'h80 + 16 * (rnd % 2), 8'hA0 + 16 * (rnd % 2), 3'($urandom));
      csr_write(1'b1, 32'(r_desc[0]));
      csr_write(1'b0, ctl(1'b1, 1'b1, 1'b0, 1 + int'($urandom % 8), 0, 0));
      collect(30, 1'b1, "R1 random ring stream");
      stop_and_drain("R7 random drain");
      csr_read(1'b0, v);
    end

    summary();
    $finish;
  end
endmodule